// File: doc/BRIEF.md
# Dynamic Bus Sizing Bus Controller

This block is a bus-master sequencer that sits between an internal requester and an external asynchronous-style bus with a 16-bit data path. The requester asks for a read or a write of a 1-, 2- or 4-byte operand at any byte address. The controller drives the address, an address strobe, a data strobe and a read/write line. It then waits for the addressed slave to terminate the cycle. The slave reports its own port width through a two-bit active-low acknowledge code on every cycle, and the controller uses that code to decide how many bytes the cycle moved.

The controller keeps running bus cycles until the whole operand has been moved. After each cycle the address advances by the bytes just transferred. Read bytes are packed into a right-justified big-endian result, and write bytes are placed on fixed byte lanes that suit both port widths. A bus error input ends the transfer at once. An autovector input ends interrupt-acknowledge cycles only. Each case is reported with a flag on a one-clock completion pulse.

Top module: `dbs_bus_ctrl`

## Requirements
- R1: On a read cycle the data strobe `bus_ds_n` goes low in the same clock in which `bus_as_n` goes low.
- R2: On a write cycle the data strobe stays high in the first clock of the address strobe and goes low one clock later.
- R3: While a cycle waits, the acknowledge code `dsack_n` is decoded as follows: 2'b11 and 2'b00 keep the cycle waiting with both strobes low; 2'b10 completes it for a port 8 bits wide; 2'b01 completes it for a port 16 bits wide.
- R4: The cycle count and the byte steps are fixed. A cycle to an 8-bit port moves 1 byte. A cycle to a 16-bit port moves 2 bytes from an even address when 2 or more bytes remain, and 1 byte otherwise. The next cycle's address is the previous address plus the bytes moved. So a 4-byte operand at an even address takes 2 cycles on a 16-bit port and 4 cycles on an 8-bit port.
- R5: Read lanes are fixed. A 16-bit port supplies the even-address byte on `bus_din[15:8]` and the odd-address byte on `bus_din[7:0]`. An 8-bit port supplies its byte on `bus_din[15:8]`. `done_rdata` holds the operand with the lowest-addressed byte most significant, right-justified (byte in [7:0], word in [15:0]).
- R6: Write lanes are fixed. At an even address the next operand byte goes on `bus_dout[15:8]`, and `bus_dout[7:0]` carries the byte after it, or the same byte again if only one byte remains. At an odd address the next operand byte goes on both lanes. `bus_doe` is high while a write cycle's strobes are asserted.
- R7: Both strobes are high in the clock after the clock edge that terminates a cycle. `done` is high for exactly that one clock after the last cycle of a transfer, together with `done_rdata` and the flags.
- R8: A low `berr_n` terminates the cycle even when an acknowledge code is present. It ends the transfer with no further cycles and sets `done_berr`. `done_exc` is also set when `halt_n` is low in the same clock.
- R9: On an interrupt-acknowledge request (`req_iack`=1), a low `avec_n` terminates the cycle, ends the transfer and sets `done_avec`. In any other cycle `avec_n` has no effect.
- R10: A request is taken only while `req_ready` is high. `req_ready` is low from the first clock of the address strobe until the transfer ends, and request inputs driven in that time do not change the transfer.
- R11: Request size codes are: 2'd0 byte, 2'd1 word, 2'd2 and 2'd3 long word (4 bytes). After reset both strobes and `bus_doe` are low-active idle (strobes high, enable low), `req_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (R11) |
| req_iack | input | 1 | Request is an interrupt-acknowledge cycle |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Right-justified write operand |
| req_ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-clock transfer completion pulse |
| done_rdata | output | 32 | Assembled read operand |
| done_berr | output | 1 | Transfer ended by bus error |
| done_exc | output | 1 | Bus error together with halt |
| done_avec | output | 1 | Transfer ended by autovector |
| bus_addr | output | ADDR_W | External byte address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_dout | output | 16 | Write data lanes |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data lanes |
| dsack_n | input | 2 | Acknowledge code, active low, bit 1 and bit 0 |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| avec_n | input | 1 | Autovector, active low |

## Verification
The embedded properties watch, on every clock, the relation between the two strobe edges for reads and writes. They also check that strobes are released after any termination, that the reserved code and a non-acknowledge autovector keep a cycle waiting, that a bus error closes the transfer with its flag, and that each cycle's byte step fits in what remains. The scenarios alone show the data behaviour: the lane each byte travels on, the address sequence, the number of cycles for each port width and alignment, and the packed read value. The bench also shows that nothing more runs after a bus error, and that requests driven while busy are ignored.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int OP_W     = 32;
  localparam int BUS_W    = 16;
  localparam int OP_BYTES = OP_W / 8;
  localparam int CNT_W    = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RECOV = 2'd3
  } bus_state_e;

  // Number of bytes named by a request size code.
  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      default: return CNT_W'(4);
    endcase
  endfunction

  // Bytes moved by one cycle, given the reported port width and alignment.
  function automatic logic [CNT_W-1:0] step_bytes(input logic port16,
                                                  input logic a0,
                                                  input logic [CNT_W-1:0] rem);
    if (port16 && !a0 && (rem >= CNT_W'(2))) return CNT_W'(2);
    return CNT_W'(1);
  endfunction

  // Byte idx of an operand of nb bytes, idx 0 being the lowest address.
  function automatic logic [7:0] op_byte(input logic [OP_W-1:0] op,
                                         input logic [CNT_W-1:0] nb,
                                         input logic [CNT_W-1:0] idx);
    logic [CNT_W-1:0] pos;
    pos = nb - CNT_W'(1) - idx;
    return op[{pos[1:0], 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode (
  input  logic       window,
  input  logic       iack,
  input  logic [1:0] dsack_n,
  input  logic       berr_n,
  input  logic       halt_n,
  input  logic       avec_n,
  output logic       ev_berr,
  output logic       ev_exc,
  output logic       ev_avec,
  output logic       ev_ack,
  output logic       port16,
  output logic       ev_term
);

  logic code_done;

  always_comb begin
    // only the two mixed codes finish a cycle; 11 and 00 both mean wait
    code_done = (dsack_n == 2'b10) || (dsack_n == 2'b01);
    port16    = (dsack_n == 2'b01);
    ev_berr   = window && !berr_n;
    ev_exc    = ev_berr && !halt_n;
    ev_avec   = window && berr_n && iack && !avec_n;
    ev_ack    = window && berr_n && !ev_avec && code_done;
    ev_term   = ev_berr || ev_avec || ev_ack;
  end

endmodule

// File: rtl/dbs_lane_unit.sv
module dbs_lane_unit
  import dbs_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [CNT_W-1:0] rem,
  input  logic             a0,
  input  logic             port16,
  input  logic [BUS_W-1:0] din,
  output logic [CNT_W-1:0] step,
  output logic [BUS_W-1:0] dout,
  output logic [BUS_W-1:0] rd_bytes
);

  logic [CNT_W-1:0] idx;
  logic [7:0]       b_first;
  logic [7:0]       b_next;

  always_comb begin
    idx     = nbytes - rem;
    b_first = op_byte(op, nbytes, idx);
    b_next  = (rem >= CNT_W'(2)) ? op_byte(op, nbytes, idx + CNT_W'(1)) : b_first;
    // upper lane always carries the next byte so a narrow port finds it there
    dout    = a0 ? {b_first, b_first} : {b_first, b_next};
    step    = step_bytes(port16, a0, rem);
    if (step == CNT_W'(2))
      rd_bytes = din;
    else if (port16 && a0)
      rd_bytes = {8'h00, din[7:0]};
    else
      rd_bytes = {8'h00, din[15:8]};
  end

endmodule

// File: rtl/dbs_xfer_track.sv
module dbs_xfer_track
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_iack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OP_W-1:0]   req_wdata,
  input  logic              ev_ack,
  input  logic              ev_berr,
  input  logic              ev_exc,
  input  logic              ev_avec,
  input  logic [CNT_W-1:0]  step,
  input  logic [BUS_W-1:0]  rd_bytes,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  nbytes,
  output logic [CNT_W-1:0]  rem,
  output logic              wr,
  output logic              iack,
  output logic [OP_W-1:0]   op,
  output logic [OP_W-1:0]   acc,
  output logic              f_berr,
  output logic              f_exc,
  output logic              f_avec,
  output logic              ev_fin
);

  assign ev_fin = ev_berr || ev_avec || (ev_ack && (step == rem));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      nbytes <= '0;
      rem    <= '0;
      wr     <= 1'b0;
      iack   <= 1'b0;
      op     <= '0;
      acc    <= '0;
      f_berr <= 1'b0;
      f_exc  <= 1'b0;
      f_avec <= 1'b0;
    end else if (start) begin
      addr   <= req_addr;
      nbytes <= size_bytes(req_size);
      rem    <= size_bytes(req_size);
      wr     <= req_write;
      iack   <= req_iack;
      op     <= req_wdata;
      acc    <= '0;
      f_berr <= 1'b0;
      f_exc  <= 1'b0;
      f_avec <= 1'b0;
    end else begin
      if (ev_ack) begin
        addr <= addr + ADDR_W'(step);
        rem  <= rem - step;
        if (!wr) begin
          if (step == CNT_W'(2)) acc <= {acc[OP_W-17:0], rd_bytes};
          else                   acc <= {acc[OP_W-9:0], rd_bytes[7:0]};
        end
      end
      if (ev_berr) begin
        f_berr <= 1'b1;
        f_exc  <= ev_exc;
      end
      if (ev_avec) f_avec <= 1'b1;
    end
  end

  // R4
  step_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |-> (step != '0) && (step <= rem));

  // R4
  addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !start) |=> (addr == $past(addr) + ADDR_W'($past(step))));

endmodule

// File: rtl/dbs_cycle_fsm.sv
module dbs_cycle_fsm
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       wr,
  input  logic       ev_term,
  input  logic       ev_fin,
  output bus_state_e state,
  output logic       start,
  output logic       as_n,
  output logic       ds_n,
  output logic       window,
  output logic       ready,
  output logic       done
);

  bus_state_e state_nx;
  logic       fin_q;

  always_comb begin
    ready  = (state == ST_IDLE);
    start  = ready && req_valid;
    window = (state == ST_WAIT);
    as_n   = !((state == ST_ADDR) || (state == ST_WAIT));
    // reads strobe data with the address; writes hold data strobe off a clock
    ds_n   = !(((state == ST_ADDR) && !wr) || (state == ST_WAIT));
    done   = (state == ST_RECOV) && fin_q;
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = ST_ADDR;
      ST_ADDR:  state_nx = ST_WAIT;
      ST_WAIT:  if (ev_term) state_nx = ST_RECOV;
      ST_RECOV: state_nx = fin_q ? ST_IDLE : ST_ADDR;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      fin_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (ev_term) fin_q <= ev_fin;
    end
  end

  // R1
  rd_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && !wr) |-> !ds_n);

  // R2
  wr_ds_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && wr) |-> ds_n ##1 !ds_n);

  // R7
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_term |=> (as_n && ds_n));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !ready);

endmodule

// File: rtl/dbs_bus_ctrl.sv
module dbs_bus_ctrl
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_iack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [31:0]       done_rdata,
  output logic              done_berr,
  output logic              done_exc,
  output logic              done_avec,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_rd,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic [1:0]        dsack_n,
  input  logic              berr_n,
  input  logic              halt_n,
  input  logic              avec_n
);

  bus_state_e       state;
  logic             start, window;
  logic             ev_berr, ev_exc, ev_avec, ev_ack, port16, ev_term, ev_fin;
  logic [CNT_W-1:0] step, nbytes, rem;
  logic [BUS_W-1:0] rd_bytes, lane_out;
  logic [ADDR_W-1:0] addr;
  logic             wr, iack;
  logic [OP_W-1:0]  op, acc;
  logic             f_berr, f_exc, f_avec;

  dbs_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr(wr),
    .ev_term(ev_term), .ev_fin(ev_fin), .state(state), .start(start),
    .as_n(bus_as_n), .ds_n(bus_ds_n), .window(window),
    .ready(req_ready), .done(done)
  );

  dbs_ack_decode u_ack (
    .window(window), .iack(iack), .dsack_n(dsack_n), .berr_n(berr_n),
    .halt_n(halt_n), .avec_n(avec_n), .ev_berr(ev_berr), .ev_exc(ev_exc),
    .ev_avec(ev_avec), .ev_ack(ev_ack), .port16(port16), .ev_term(ev_term)
  );

  dbs_lane_unit u_lane (
    .op(op), .nbytes(nbytes), .rem(rem), .a0(addr[0]), .port16(port16),
    .din(bus_din), .step(step), .dout(lane_out), .rd_bytes(rd_bytes)
  );

  dbs_xfer_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
    .req_size(req_size), .req_iack(req_iack), .req_addr(req_addr),
    .req_wdata(req_wdata), .ev_ack(ev_ack), .ev_berr(ev_berr),
    .ev_exc(ev_exc), .ev_avec(ev_avec), .step(step), .rd_bytes(rd_bytes),
    .addr(addr), .nbytes(nbytes), .rem(rem), .wr(wr), .iack(iack),
    .op(op), .acc(acc), .f_berr(f_berr), .f_exc(f_exc), .f_avec(f_avec),
    .ev_fin(ev_fin)
  );

  always_comb begin
    bus_addr   = addr;
    bus_rd     = !wr;
    bus_doe    = wr && ((state == ST_ADDR) || (state == ST_WAIT));
    bus_dout   = lane_out;
    done_rdata = acc;
    done_berr  = f_berr;
    done_exc   = f_exc;
    done_avec  = f_avec;
  end

  // R3
  reserved_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window && berr_n && (dsack_n == 2'b00) && !(iack && !avec_n)) |=> !bus_as_n);

  // R9
  avec_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window && !iack && !avec_n && berr_n && (dsack_n[1] == dsack_n[0])) |=> !bus_as_n);

  // R8
  berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window && !berr_n) |=> (done && done_berr && bus_as_n));

  // R9
  avec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window && iack && !avec_n && berr_n) |=> (done && done_avec));

endmodule

// File: tb/dbs_bus_ctrl_test.sv
module dbs_bus_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_iack = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, done, done_berr, done_exc, done_avec;
  logic [31:0]   done_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_as_n, bus_ds_n, bus_rd, bus_doe;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    dsack_n = 2'b11;
  logic          berr_n = 1'b1, halt_n = 1'b1, avec_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mem [0:63];

  dbs_bus_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_iack(req_iack), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .done_rdata(done_rdata), .done_berr(done_berr), .done_exc(done_exc),
    .done_avec(done_avec), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
    .bus_ds_n(bus_ds_n), .bus_rd(bus_rd), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .dsack_n(dsack_n),
    .berr_n(berr_n), .halt_n(halt_n), .avec_n(avec_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_clk();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int nbytes_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // operand byte k, counted from the lowest address
  function automatic logic [7:0] wbyte(input logic [31:0] wd, input int nb, input int k);
    logic [31:0] t;
    t = wd >> (8 * (nb - 1 - k));
    return t[7:0];
  endfunction

  function automatic logic [31:0] mem_read(input int a, input int nb);
    logic [31:0] v = 0;
    for (int i = 0; i < nb; i++) v = (v << 8) | 32'(mem[(a + i) & 63]);
    return v;
  endfunction

  // one full transfer; bench is at a negedge in idle on entry and exit
  task automatic xfer(input bit wr, input logic [1:0] sz, input int a0,
                      input logic [31:0] wd, input bit p16, input int waits,
                      input bit avec_noise, output int cycles);
    int nb, a, rem, k, n;
    logic [31:0] exp_rd;
    nb = nbytes_of(sz);
    a = a0; rem = nb; k = 0; cycles = 0;
    exp_rd = mem_read(a0, nb);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_iack = 1'b0;
    req_addr = AW'(a0); req_wdata = wd;
    step_clk();
    req_valid = 1'b0;
    while (rem > 0) begin
      cycles++;
      chk(bus_as_n == 1'b0, "R1 as asserted", 32'(bus_as_n), 0);
      chk(bus_addr == AW'(a), "R4 address", 32'(bus_addr), 32'(a));
      chk(bus_rd == !wr, "R1 direction", 32'(bus_rd), 32'(!wr));
      if (wr) begin
        logic [15:0] ew;
        if (a % 2 == 1) ew = {wbyte(wd, nb, k), wbyte(wd, nb, k)};
        else ew = {wbyte(wd, nb, k), (rem >= 2) ? wbyte(wd, nb, k + 1) : wbyte(wd, nb, k)};
        chk(bus_ds_n == 1'b1, "R2 ds held off", 32'(bus_ds_n), 1);
        chk(bus_dout == ew, "R6 write lanes", 32'(bus_dout), 32'(ew));
        chk(bus_doe == 1'b1, "R6 drive enable", 32'(bus_doe), 1);
      end else begin
        chk(bus_ds_n == 1'b0, "R1 ds with as", 32'(bus_ds_n), 0);
      end
      step_clk();
      chk(bus_ds_n == 1'b0, "R2 ds asserted", 32'(bus_ds_n), 0);
      for (int w = 0; w < waits; w++) begin
        dsack_n = (w % 2 == 1) ? 2'b00 : 2'b11;
        avec_n = !avec_noise;
        req_valid = 1'b1; req_addr = AW'(a + 7); req_write = !wr;
        chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 0);
        step_clk();
        chk(bus_as_n == 1'b0 && bus_ds_n == 1'b0, "R3 wait code holds", 32'(bus_as_n), 0);
        if (avec_noise) chk(bus_as_n == 1'b0, "R9 autovector ignored", 32'(bus_as_n), 0);
      end
      req_valid = 1'b0; req_write = wr;
      dsack_n = p16 ? 2'b01 : 2'b10;
      if (p16) bus_din = {mem[(a & ~1) & 63], mem[(a | 1) & 63]};
      else     bus_din = {mem[a & 63], 8'($urandom)};
      if (p16) n = (a % 2 == 1) ? 1 : ((rem >= 2) ? 2 : 1);
      else     n = 1;
      step_clk();
      dsack_n = 2'b11; avec_n = 1'b1;
      chk(bus_as_n && bus_ds_n, "R7 strobes released", {bus_as_n, bus_ds_n}, 3);
      a += n; rem -= n; k += n;
      if (rem == 0) begin
        chk(done == 1'b1, "R7 done pulse", 32'(done), 1);
        if (!wr) chk(done_rdata == exp_rd, "R5 read data", done_rdata, exp_rd);
        chk({done_berr, done_avec} == 2'b00, "R9 no flags", {done_berr, done_avec}, 0);
      end else begin
        chk(done == 1'b0, "R7 no early done", 32'(done), 0);
      end
      step_clk();
    end
    chk(bus_as_n && req_ready && !done, "R10 idle after", {bus_as_n, req_ready, done}, 3'b110);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    int cyc;
    void'($urandom(32'd5150));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(bus_as_n && bus_ds_n && !bus_doe, "R11 idle strobes", {bus_as_n, bus_ds_n, bus_doe}, 3'b110);
    chk(req_ready && !done, "R11 ready", {req_ready, done}, 2'b10);

    // R4 directed counts
    xfer(1'b0, 2'd2, 8, 0, 1'b1, 1, 1'b0, cyc);
    chk(cyc == 2, "R4 long 16-bit port", cyc, 2);
    xfer(1'b0, 2'd2, 12, 0, 1'b0, 0, 1'b0, cyc);
    chk(cyc == 4, "R4 long 8-bit port", cyc, 4);
    xfer(1'b0, 2'd1, 20, 0, 1'b1, 2, 1'b0, cyc);
    chk(cyc == 1, "R4 word 16-bit even", cyc, 1);
    xfer(1'b0, 2'd1, 21, 0, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 2, "R5 odd word 16-bit", cyc, 2);
    xfer(1'b0, 2'd3, 31, 0, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 3, "R4 long odd 16-bit", cyc, 3);
    xfer(1'b1, 2'd0, 5, 32'h0000_00A7, 1'b1, 0, 1'b0, cyc);
    xfer(1'b1, 2'd2, 2, 32'h1234_5678, 1'b0, 1, 1'b0, cyc);
    xfer(1'b1, 2'd2, 3, 32'h89AB_CDEF, 1'b1, 0, 1'b0, cyc);
    // R9 autovector ignored on a plain read (with reserved code waits, R3)
    xfer(1'b0, 2'd1, 40, 0, 1'b1, 3, 1'b1, cyc);

    // R8 bus error with acknowledge present and halt
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 24'd16; req_iack = 1'b0;
    step_clk();
    req_valid = 1'b0;
    step_clk();
    berr_n = 1'b0; halt_n = 1'b0; dsack_n = 2'b01;
    step_clk();
    berr_n = 1'b1; halt_n = 1'b1; dsack_n = 2'b11;
    chk(done && done_berr && done_exc, "R8 berr with halt", {done, done_berr, done_exc}, 3'b111);
    step_clk();
    step_clk();
    chk(bus_as_n && req_ready, "R8 no further cycle", {bus_as_n, req_ready}, 2'b11);

    // R8 bus error alone
    req_valid = 1'b1; req_addr = 24'd18;
    step_clk();
    req_valid = 1'b0;
    step_clk();
    berr_n = 1'b0;
    step_clk();
    berr_n = 1'b1;
    chk(done && done_berr && !done_exc, "R8 berr no halt", {done, done_berr, done_exc}, 3'b110);
    step_clk();

    // R9 autovector ends an interrupt acknowledge
    req_valid = 1'b1; req_iack = 1'b1; req_size = 2'd0; req_addr = 24'd1;
    step_clk();
    req_valid = 1'b0; req_iack = 1'b0;
    step_clk();
    avec_n = 1'b0;
    step_clk();
    avec_n = 1'b1;
    chk(done && done_avec && !done_berr, "R9 autovector end", {done, done_avec, done_berr}, 3'b110);
    step_clk();
    chk(bus_as_n && req_ready, "R9 idle after autovector", {bus_as_n, req_ready}, 2'b11);

    // random mix
    for (int t = 0; t < 60; t++) begin
      xfer(1'($urandom), 2'($urandom), int'($urandom % 56), $urandom,
           1'($urandom), int'($urandom % 4), 1'($urandom), cyc);
    end
    finish_run();
  end

endmodule